// File: doc/BRIEF.md
# Conditioning RF Burst Sequencer

This block produces the digital drive for conditioning an RF transmission line. Power goes out as short bursts rather than as a continuous wave. Each burst is started by an external repetition pulse and lasts a programmed number of clock cycles. During a burst the phase-accumulator frequency word sweeps away from a start value, and the burst is then cut off. The amplitude word rises by a programmed step after every burst that finishes cleanly, so the line is brought toward full power gradually.

A digital flag reports whether the coupler vacuum is healthy. If the vacuum goes bad during a burst, the gate closes on the next clock edge and the amplitude is pulled back by a separate back-off step. No new bursts start until the vacuum recovers. A drive-permit flag must also be true for the gate to open. Lowering the run input stops conditioning and reloads the start amplitude.

The logic is intended for a 35.22 MHz system clock. The repetition pulse is synchronous to that clock. Sine lookup, DAC handling and vacuum gauge readout are handled outside this block.

Top module: `cond_burst_seq`

## Requirements
- R1: While reset is asserted, status is 0, the gate is low, and the amplitude and frequency words are 0.
- R2: While running and at rest, a rising edge on the repetition input with vacuum healthy starts a burst, and the gate opens on the next clock edge. The burst lasts `cfg_burst_len_i` cycles, and a length of 0 is treated as 1.
- R3: During a burst, the gate in each cycle equals the drive-permit input sampled at the edge that produced that cycle. A lowered permit does not shorten the burst.
- R4: In the first burst cycle the frequency word equals the start frequency. Each later burst cycle adds the signed step to the offset, which is clamped to the range from minus span to plus span. Outside a burst the word returns to the start frequency.
- R5: When a burst completes without fault, the amplitude rises by the step and saturates at the ceiling.
- R6: A vacuum fault seen during a burst closes the gate on the next edge and lowers the amplitude by the back-off step, floored at 0. The block then stays faulted until the vacuum flag is healthy again.
- R7: A repetition edge has no effect while a burst is in progress, while faulted, or while at rest with the vacuum flag bad.
- R8: With run low, the block goes to rest, aborts any burst, closes the gate and holds the amplitude at the start value.
- R9: Status encoding is 0 = idle, 1 = bursting, 2 = faulted, 3 = at rest with the amplitude at or above the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Conditioning enabled |
| rep_pulse_i | input | 1 | Repetition pulse; a rising edge requests a burst |
| vac_ok_i | input | 1 | Coupler vacuum healthy flag |
| drive_permit_i | input | 1 | RF drive permitted flag |
| cfg_amp_start_i | input | AMP_W | Amplitude loaded while not running |
| cfg_amp_step_i | input | AMP_W | Amplitude increment per clean burst |
| cfg_amp_ceil_i | input | AMP_W | Amplitude ceiling |
| cfg_amp_backoff_i | input | AMP_W | Amplitude decrement on vacuum fault |
| cfg_burst_len_i | input | LEN_W | Burst length in cycles |
| cfg_freq_start_i | input | FREQ_W | Frequency word at burst start |
| cfg_freq_step_i | input | FREQ_W | Signed per-cycle frequency step |
| cfg_sweep_span_i | input | FREQ_W-1 | Sweep offset magnitude limit |
| gate_o | output | 1 | RF gate |
| amp_o | output | AMP_W | Current amplitude word |
| freq_o | output | FREQ_W | Frequency word |
| status_o | output | 2 | Sequencer status |

## Verification
A ramp of clean bursts separates correct stepping from saturation, because the amplitude must stop exactly at the ceiling and the status must change to 3. Sweeps with a positive step and with a negative step run long enough to reach the clamp, which shows both the sign handling and the limit. Faults injected at a high amplitude and at a low amplitude separate the back-off from the zero floor. Repetition edges sent during a burst, during a fault, with the vacuum flag bad at rest and with run low show that these edges are ignored. A permit drop in the middle of a burst shows that the gate follows the permit flag while the burst timing does not.

// File: rtl/cond_pkg.sv
package cond_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FAULT = 2'd2,
        ST_TOP   = 2'd3
    } cond_state_e;

endpackage

// File: rtl/cond_edge_det.sv
module cond_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

endmodule

// File: rtl/cond_sweep_next.sv
module cond_sweep_next #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] ofs_i,
    input  logic signed [W-1:0] step_i,
    input  logic        [W-2:0] span_i,
    output logic signed [W-1:0] ofs_o
);

    localparam int XW = W + 2;

    logic signed [XW-1:0] sum_x, hi_x, lo_x;

    always_comb begin
        sum_x = XW'(ofs_i) + XW'(step_i);
        hi_x  = signed'(XW'(span_i));
        lo_x  = -hi_x;
        if (sum_x > hi_x)      ofs_o = W'(hi_x);
        else if (sum_x < lo_x) ofs_o = W'(lo_x);
        else                   ofs_o = W'(sum_x);
    end

endmodule

// File: rtl/cond_level_next.sv
module cond_level_next #(
    parameter int W = 12
) (
    input  logic [W-1:0] amp_i,
    input  logic [W-1:0] step_i,
    input  logic [W-1:0] ceil_i,
    input  logic [W-1:0] backoff_i,
    output logic [W-1:0] up_o,
    output logic [W-1:0] down_o
);

    localparam int XW = W + 1;

    logic [XW-1:0] up_x;

    always_comb begin
        up_x = XW'(amp_i) + XW'(step_i);
        if (up_x >= XW'(ceil_i)) up_o = ceil_i;
        else                     up_o = up_x[W-1:0];
        if (amp_i > backoff_i)   down_o = amp_i - backoff_i;
        else                     down_o = '0;
    end

endmodule

// File: rtl/cond_burst_seq.sv
module cond_burst_seq
    import cond_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int AMP_W  = 12,
    parameter int LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              rep_pulse_i,
    input  logic              vac_ok_i,
    input  logic              drive_permit_i,
    input  logic [AMP_W-1:0]  cfg_amp_start_i,
    input  logic [AMP_W-1:0]  cfg_amp_step_i,
    input  logic [AMP_W-1:0]  cfg_amp_ceil_i,
    input  logic [AMP_W-1:0]  cfg_amp_backoff_i,
    input  logic [LEN_W-1:0]  cfg_burst_len_i,
    input  logic [FREQ_W-1:0] cfg_freq_start_i,
    input  logic [FREQ_W-1:0] cfg_freq_step_i,
    input  logic [FREQ_W-2:0] cfg_sweep_span_i,
    output logic              gate_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic [1:0]        status_o
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        cond_state_e               st;
        logic [LEN_W-1:0]          cnt;
        logic signed [FREQ_W-1:0]  ofs;
        logic [AMP_W-1:0]          amp;
        logic                      gate;
        logic [FREQ_W-1:0]         freq;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic                     rep_rise;
    logic signed [FREQ_W-1:0] ofs_step;
    logic [AMP_W-1:0]         amp_up, amp_down;
    logic [LEN_W-1:0]         first_cnt;

    cond_edge_det i_rep_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (rep_pulse_i),
        .rise_o (rep_rise)
    );

    cond_sweep_next #(.W(FREQ_W)) i_sweep (
        .ofs_i  (r_q.ofs),
        .step_i (signed'(cfg_freq_step_i)),
        .span_i (cfg_sweep_span_i),
        .ofs_o  (ofs_step)
    );

    cond_level_next #(.W(AMP_W)) i_level (
        .amp_i     (r_q.amp),
        .step_i    (cfg_amp_step_i),
        .ceil_i    (cfg_amp_ceil_i),
        .backoff_i (cfg_amp_backoff_i),
        .up_o      (amp_up),
        .down_o    (amp_down)
    );

    function automatic cond_state_e rest_of(input logic [AMP_W-1:0] a,
                                            input logic [AMP_W-1:0] c);
        return (a >= c) ? ST_TOP : ST_IDLE;
    endfunction

    always_comb begin
        first_cnt = (cfg_burst_len_i == '0) ? '0 : cfg_burst_len_i - LEN_ONE;
        r_d = r_q;
        if (!run_i) begin
            r_d.st   = ST_IDLE;
            r_d.amp  = cfg_amp_start_i;
            r_d.cnt  = '0;
            r_d.ofs  = '0;
            r_d.gate = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE, ST_TOP: begin
                    if (rep_rise && vac_ok_i) begin
                        r_d.st   = ST_BURST;
                        r_d.cnt  = first_cnt;
                        r_d.ofs  = '0;
                        r_d.gate = drive_permit_i;
                    end else begin
                        r_d.st   = rest_of(r_q.amp, cfg_amp_ceil_i);
                    end
                end
                ST_BURST: begin
                    if (!vac_ok_i) begin
                        r_d.st   = ST_FAULT;
                        r_d.gate = 1'b0;
                        r_d.amp  = amp_down;
                        r_d.ofs  = '0;
                    end else if (r_q.cnt == '0) begin
                        r_d.st   = rest_of(amp_up, cfg_amp_ceil_i);
                        r_d.gate = 1'b0;
                        r_d.amp  = amp_up;
                        r_d.ofs  = '0;
                    end else begin
                        r_d.cnt  = r_q.cnt - LEN_ONE;
                        r_d.ofs  = ofs_step;
                        r_d.gate = drive_permit_i;
                    end
                end
                ST_FAULT: begin
                    r_d.gate = 1'b0;
                    if (vac_ok_i) r_d.st = rest_of(r_q.amp, cfg_amp_ceil_i);
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
        r_d.freq = cfg_freq_start_i + $unsigned(r_d.ofs);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        gate_o   = r_q.gate;
        amp_o    = r_q.amp;
        freq_o   = r_q.freq;
        status_o = r_q.st;
    end

    AST_GATE_ONLY_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> (status_o == ST_BURST)); // R9

    AST_GATE_NEEDS_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_o |-> $past(drive_permit_i)); // R3

    AST_FAULT_CLOSES_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_BURST && run_i && !vac_ok_i) |=> (!gate_o && status_o == ST_FAULT)); // R6

    AST_BACKOFF_NOT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_BURST && run_i && !vac_ok_i) |=> (amp_o <= $past(amp_o))); // R6

    AST_AMP_UNDER_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_BURST && run_i && vac_ok_i && r_q.cnt == '0)
        |=> (amp_o <= $past(cfg_amp_ceil_i))); // R5

    AST_RUN_LOW_RESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!gate_o && status_o == ST_IDLE)); // R8

    AST_NO_REP_WHILE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_FAULT && run_i && !vac_ok_i) |=> (status_o == ST_FAULT)); // R7

endmodule

// File: tb/test_cond_burst_seq.sv
`timescale 1ns/1ps
module test_cond_burst_seq;

    localparam int CLK_PERIOD = 28;
    localparam int FW = 24;
    localparam int AW = 12;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, rep = 1'b0, vac = 1'b1, permit = 1'b1;
    logic [AW-1:0] a_start = '0, a_step = '0, a_ceil = '0, a_back = '0;
    logic [LW-1:0] len = '0;
    logic [FW-1:0] f_start = '0;
    logic signed [FW-1:0] f_step = '0;
    logic [FW-2:0] span = '0;
    logic gate;
    logic [AW-1:0] amp;
    logic [FW-1:0] freq;
    logic [1:0] status;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_burst_seq #(.FREQ_W(FW), .AMP_W(AW), .LEN_W(LW)) i_cond_burst_seq (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .rep_pulse_i(rep),
        .vac_ok_i(vac), .drive_permit_i(permit),
        .cfg_amp_start_i(a_start), .cfg_amp_step_i(a_step),
        .cfg_amp_ceil_i(a_ceil), .cfg_amp_backoff_i(a_back),
        .cfg_burst_len_i(len), .cfg_freq_start_i(f_start),
        .cfg_freq_step_i(f_step), .cfg_sweep_span_i(span),
        .gate_o(gate), .amp_o(amp), .freq_o(freq), .status_o(status)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit cmp_en = 1'b0;

    // behavioural reference: 0 idle, 1 burst, 2 fault, 3 ceiling
    int m_st = 0, m_amp = 0, m_cnt = 0, m_ofs = 0, m_gate = 0, m_freq = 0;
    int m_rep_prev = 0;

    function automatic int rest_code(int a, int c);
        return (a >= c) ? 3 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_amp = 0; m_cnt = 0; m_ofs = 0; m_gate = 0; m_freq = 0; m_rep_prev = 0;
        end else begin
            int rise;
            int s;
            rise = (rep && m_rep_prev == 0) ? 1 : 0;
            m_rep_prev = rep;
            if (!run) begin
                m_st = 0; m_amp = a_start; m_cnt = 0; m_ofs = 0; m_gate = 0;
            end else if (m_st == 0 || m_st == 3) begin
                if (rise == 1 && vac) begin
                    m_st = 1; m_cnt = (len == 0) ? 1 : int'(len); m_ofs = 0; m_gate = permit;
                end else m_st = rest_code(m_amp, a_ceil);
            end else if (m_st == 1) begin
                if (!vac) begin
                    m_st = 2; m_gate = 0; m_ofs = 0;
                    m_amp = (m_amp > a_back) ? m_amp - a_back : 0;
                end else if (m_cnt == 1) begin
                    m_amp = m_amp + a_step;
                    if (m_amp > a_ceil) m_amp = a_ceil;
                    m_st = rest_code(m_amp, a_ceil); m_gate = 0; m_ofs = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                    s = m_ofs + int'(f_step);
                    if (s > int'(span)) s = int'(span);
                    if (s < -int'(span)) s = -int'(span);
                    m_ofs = s; m_gate = permit;
                end
            end else begin
                m_gate = 0;
                if (vac) m_st = rest_code(m_amp, a_ceil);
            end
            m_freq = (int'(f_start) + m_ofs) & 32'h00FF_FFFF;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R9 status", int'(status), m_st);
            chk("R3 gate", int'(gate), m_gate);
            chk("R5 amp", int'(amp), m_amp);
            chk("R4 freq", int'(freq), m_freq);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
            $finish;
        end
    end

    task automatic burst_count(input int ncyc, output int g);
        rep = 1'b1;
        g = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            rep = 1'b0;
            if (gate) g++;
        end
    endtask

    int g;
    int fmin;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset gate", int'(gate), 0);
        chk("R1 reset amp", int'(amp), 0);
        chk("R1 reset freq", int'(freq), 0);
        a_start = 100; a_step = 50; a_ceil = 300; a_back = 80; len = 5;
        f_start = 1000; f_step = 7; span = 20;
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 start amp loaded", int'(amp), 100);
        run = 1'b1;
        @(negedge clk);

        // R2 and R5: clean ramp
        burst_count(10, g);
        chk("R2 gate length", g, 5);
        chk("R5 amp stepped", int'(amp), 150);
        for (int k = 0; k < 3; k++) burst_count(10, g);
        chk("R5 amp at ceiling", int'(amp), 300);
        chk("R9 ceiling status", int'(status), 3);
        burst_count(10, g);
        chk("R5 amp saturated", int'(amp), 300);

        // R3: permit dropped mid-burst
        rep = 1'b1; g = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (gate) g++;
            if (i == 1) rep = 1'b0;
            if (i == 2) permit = 1'b0;
            if (i == 4) permit = 1'b1;
        end
        chk("R3 gated cycles", g, 3);

        // R4: negative sweep into clamp
        f_step = -9; len = 8;
        rep = 1'b1; fmin = 1000;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            rep = 1'b0;
            if (int'(freq) < fmin) fmin = int'(freq);
        end
        chk("R4 clamp low", fmin, 980);
        chk("R4 rest freq", int'(freq), 1000);

        // R7: edge during burst ignored
        len = 10;
        rep = 1'b1; @(negedge clk); rep = 1'b0; @(negedge clk);
        rep = 1'b1; @(negedge clk); rep = 1'b0;
        g = 0;
        for (int i = 0; i < 14; i++) begin @(negedge clk); if (gate) g++; end
        chk("R7 no retrigger in burst", g, 7);

        // R6: fault back-off
        len = 20;
        rep = 1'b1; @(negedge clk); rep = 1'b0;
        repeat (2) @(negedge clk);
        vac = 1'b0;
        @(negedge clk);
        chk("R6 gate closed", int'(gate), 0);
        chk("R6 fault status", int'(status), 2);
        chk("R6 amp backed off", int'(amp), 220);
        rep = 1'b1; repeat (2) @(negedge clk);
        chk("R7 edge ignored in fault", int'(status), 2);
        vac = 1'b1; @(negedge clk); rep = 1'b0; @(negedge clk);
        chk("R6 recovered", int'(status), 0);

        // R6: floor at zero
        a_back = 500;
        rep = 1'b1; @(negedge clk); rep = 1'b0; @(negedge clk);
        vac = 1'b0; @(negedge clk);
        chk("R6 amp floored", int'(amp), 0);
        vac = 1'b1; repeat (2) @(negedge clk);

        // R2: zero length acts as one
        len = 0;
        burst_count(5, g);
        chk("R2 zero length", g, 1);
        chk("R5 step from zero", int'(amp), 50);

        // R7: bad vacuum at rest blocks start
        vac = 1'b0; @(negedge clk);
        burst_count(5, g);
        chk("R7 no burst with bad vacuum", g, 0);
        chk("R7 status at rest", int'(status), 0);
        vac = 1'b1; @(negedge clk);

        // R8: run low aborts burst
        len = 20;
        rep = 1'b1; @(negedge clk); rep = 1'b0; repeat (2) @(negedge clk);
        run = 1'b0; @(negedge clk);
        chk("R8 gate off", int'(gate), 0);
        chk("R8 status idle", int'(status), 0);
        chk("R8 amp reloaded", int'(amp), 100);
        burst_count(5, g);
        chk("R8 no burst when stopped", g, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule